// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block converts one PWM command into two gate-enable outputs, one for the high-side switch and one for the low-side switch of a synchronous buck stage. Three qualifiers decide which switch is requested. The first is an active-low shutdown. The second is a low-side allow input, which keeps the low-side switch off during start-up into a pre-biased output. The third is a supply-valid flag from an undervoltage detector.

Break-before-make is closed-loop. Before the block turns a switch on, it waits until the comparator flag for the opposite gate reports that gate below its turn-off threshold. It then waits a programmable dead time before asserting the new enable. If that flag stays high for too long, the block enters a latched fault with both enables off. Only reset clears the fault. The command pins and the supply-valid flag go through two-flop synchronizers. The two feedback flags are expected to be synchronous to the clock already.

Top module: `hb_gate_seq`

## Requirements
- R1: While the synchronized shutdown input is low (shdn_n = 0), hs_en and ls_en are both 0, whatever pwm and sync are doing.
- R2: While shdn_n = 1, uvlo_ok = 1 and sync = 0, hs_en follows pwm and ls_en stays 0.
- R3: While shdn_n = 1, uvlo_ok = 1 and sync = 1, pwm = 1 requests the high side only and pwm = 0 requests the low side only.
- R4: While the synchronized uvlo_ok is 0, hs_en and ls_en are both 0.
- R5: hs_en and ls_en are never 1 in the same cycle.
- R6: ls_en does not rise unless hs_gate_high was 0 in the cycle before. hs_en does not rise unless ls_gate_high was 0 in the cycle before. On a rising pwm, ls_en falls before hs_en can rise.
- R7: Once the opposite feedback flag reads 0, the new enable rises after dead_cycles further clock cycles (0 to 255). With dead_cycles = 0 it rises on the next edge.
- R8: If the opposite feedback flag stays 1 for timeout_cycles + 1 consecutive cycles while a handoff is waiting, fault rises. From then on, fault stays 1 and both enables stay 0 until reset.
- R9: While rst = 1 (synchronous, active high), and on the first cycle after it is released, hs_en = 0, ls_en = 0 and fault = 0.
- R10: A change on pwm, sync or shdn_n first acts on the outputs at the third rising clock edge after it is applied. Two edges are spent in the synchronizer and one in the sequencer state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm | input | 1 | PWM command from the controller (asynchronous) |
| sync | input | 1 | Low-side allow; 0 keeps the low side off (asynchronous) |
| shdn_n | input | 1 | Shutdown, active low (asynchronous) |
| uvlo_ok | input | 1 | Supply valid from the undervoltage detector (asynchronous) |
| hs_gate_high | input | 1 | High-side gate above its turn-off threshold |
| ls_gate_high | input | 1 | Low-side gate above its turn-off threshold |
| dead_cycles | input | DEAD_W | Minimum dead time in clock cycles |
| timeout_cycles | input | TO_W | Feedback wait limit in clock cycles |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| fault | output | 1 | Latched feedback-timeout fault |

## Verification
The enables come straight from the sequencer state with no extra register, so a wrong state shows at hs_en, ls_en or fault on the same edge it is entered. A lost dead-time count or a skipped wait makes an enable rise earlier or later than the exact edge the bench predicts from dead_cycles. A broken timeout counter moves the edge at which fault rises away from timeout_cycles + 1 cycles after the handoff starts. An extra or missing synchronizer stage moves every response by one edge from the third-edge latency of R10.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

  typedef enum logic [1:0] {
    TGT_OFF = 2'd0,
    TGT_HS  = 2'd1,
    TGT_LS  = 2'd2
  } tgt_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_DEAD  = 3'd2,
    ST_HS    = 3'd3,
    ST_LS    = 3'd4,
    ST_FAULT = 3'd5
  } st_e;

  // Requested switch from the qualified command inputs.
  function automatic tgt_e pick_target(input logic run_ok, input logic supply_ok,
                                       input logic ls_allow, input logic pwm_cmd);
    if (!run_ok || !supply_ok) return TGT_OFF;
    if (pwm_cmd)               return TGT_HS;
    if (ls_allow)              return TGT_LS;
    return TGT_OFF;
  endfunction

  // Feedback of the gate that must be off before the target may turn on.
  function automatic logic opposite_up(input tgt_e t, input logic hs_hi, input logic ls_hi);
    case (t)
      TGT_HS:  return ls_hi;
      TGT_LS:  return hs_hi;
      default: return 1'b0;
    endcase
  endfunction

  function automatic st_e on_state(input tgt_e t);
    return (t == TGT_HS) ? ST_HS : ST_LS;
  endfunction

endpackage

// File: rtl/hb_sync2.sv
module hb_sync2 #(
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] stg;
    always_ff @(posedge clk) begin
      if (rst) stg <= {2{RST_VAL[i]}};
      else     stg <= {stg[0], d[i]};
    end
    assign q[i] = stg[1];
  end

endmodule

// File: rtl/hb_cmd_decode.sv
module hb_cmd_decode
  import hb_gate_pkg::*;
(
  input  logic run_ok,
  input  logic supply_ok,
  input  logic ls_allow,
  input  logic pwm_cmd,
  output tgt_e target
);

  assign target = pick_target(run_ok, supply_ok, ls_allow, pwm_cmd);

endmodule

// File: rtl/hb_bbm_fsm.sv
module hb_bbm_fsm
  import hb_gate_pkg::*;
#(
  parameter int DEAD_W = 8,
  parameter int TO_W   = 12,
  localparam int CNT_W = (TO_W > DEAD_W) ? TO_W : DEAD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  tgt_e              target,
  input  logic              hs_hi,
  input  logic              ls_hi,
  input  logic [DEAD_W-1:0] dead_cycles,
  input  logic [TO_W-1:0]   timeout_cycles,
  output logic              hs_en,
  output logic              ls_en,
  output logic              fault
);

  st_e              st, st_n;
  tgt_e             tgt, tgt_n;
  logic [CNT_W-1:0] cnt, cnt_n;

  logic             opp_hi;
  logic [CNT_W-1:0] dead_lim, to_lim;

  assign opp_hi   = opposite_up(tgt, hs_hi, ls_hi);
  assign dead_lim = CNT_W'(dead_cycles);
  assign to_lim   = CNT_W'(timeout_cycles);

  always_comb begin
    st_n  = st;
    tgt_n = tgt;
    cnt_n = cnt;
    case (st)
      ST_IDLE: begin
        if (target != TGT_OFF) begin
          st_n  = ST_WAIT;
          tgt_n = target;
          cnt_n = '0;
        end
      end
      ST_HS, ST_LS: begin
        if (target != ((st == ST_HS) ? TGT_HS : TGT_LS)) begin
          if (target == TGT_OFF) begin
            st_n = ST_IDLE;
          end else begin
            st_n  = ST_WAIT;
            tgt_n = target;
            cnt_n = '0;
          end
        end
      end
      ST_WAIT: begin
        if (target == TGT_OFF) begin
          st_n = ST_IDLE;
        end else if (target != tgt) begin
          tgt_n = target;
          cnt_n = '0;
        end else if (!opp_hi) begin
          if (dead_lim == '0) begin
            st_n = on_state(tgt);
          end else begin
            st_n  = ST_DEAD;
            cnt_n = CNT_W'(1);
          end
        end else if (cnt == to_lim) begin
          st_n = ST_FAULT;
        end else begin
          cnt_n = cnt + CNT_W'(1);
        end
      end
      ST_DEAD: begin
        if (target == TGT_OFF) begin
          st_n = ST_IDLE;
        end else if (target != tgt || opp_hi) begin
          st_n  = ST_WAIT;
          tgt_n = target;
          cnt_n = '0;
        end else if (cnt >= dead_lim) begin
          st_n = on_state(tgt);
        end else begin
          cnt_n = cnt + CNT_W'(1);
        end
      end
      default: st_n = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      tgt <= TGT_OFF;
      cnt <= '0;
    end else begin
      st  <= st_n;
      tgt <= tgt_n;
      cnt <= cnt_n;
    end
  end

  assign hs_en = (st == ST_HS);
  assign ls_en = (st == ST_LS);
  assign fault = (st == ST_FAULT);

endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hb_gate_pkg::*;
#(
  parameter int DEAD_W = 8,
  parameter int TO_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwm,
  input  logic              sync,
  input  logic              shdn_n,
  input  logic              uvlo_ok,
  input  logic              hs_gate_high,
  input  logic              ls_gate_high,
  input  logic [DEAD_W-1:0] dead_cycles,
  input  logic [TO_W-1:0]   timeout_cycles,
  output logic              hs_en,
  output logic              ls_en,
  output logic              fault
);

  localparam int NSYNC = 4;

  logic [NSYNC-1:0] raw_in, synced;
  logic             shdn_s, uvlo_s, sync_s, pwm_s;
  tgt_e             target;

  assign raw_in = {shdn_n, uvlo_ok, sync, pwm};

  hb_sync2 #(.W(NSYNC), .RST_VAL('0)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (synced)
  );

  assign {shdn_s, uvlo_s, sync_s, pwm_s} = synced;

  hb_cmd_decode u_dec (
    .run_ok    (shdn_s),
    .supply_ok (uvlo_s),
    .ls_allow  (sync_s),
    .pwm_cmd   (pwm_s),
    .target    (target)
  );

  hb_bbm_fsm #(.DEAD_W(DEAD_W), .TO_W(TO_W)) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .target         (target),
    .hs_hi          (hs_gate_high),
    .ls_hi          (ls_gate_high),
    .dead_cycles    (dead_cycles),
    .timeout_cycles (timeout_cycles),
    .hs_en          (hs_en),
    .ls_en          (ls_en),
    .fault          (fault)
  );

endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk (
  input logic clk,
  input logic rst,
  input logic hs_en,
  input logic ls_en,
  input logic fault,
  input logic hs_gate_high,
  input logic ls_gate_high,
  input logic shdn_s,
  input logic uvlo_s,
  input logic sync_s
);

  assert_shdn_off_R1: assert property (@(posedge clk) disable iff (rst)
    !shdn_s |=> (!hs_en && !ls_en));

  assert_sync_low_R2: assert property (@(posedge clk) disable iff (rst)
    !sync_s |=> !ls_en);

  assert_uvlo_off_R4: assert property (@(posedge clk) disable iff (rst)
    !uvlo_s |=> (!hs_en && !ls_en));

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(hs_en && ls_en));

  assert_ls_after_hs_low_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_en) |-> !$past(hs_gate_high));

  assert_hs_after_ls_low_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_en) |-> !$past(ls_gate_high));

  assert_fault_gates_off_R8: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!hs_en && !ls_en));

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);

endmodule

bind hb_gate_seq hb_gate_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .hs_en        (hs_en),
  .ls_en        (ls_en),
  .fault        (fault),
  .hs_gate_high (hs_gate_high),
  .ls_gate_high (ls_gate_high),
  .shdn_s       (shdn_s),
  .uvlo_s       (uvlo_s),
  .sync_s       (sync_s)
);

// File: tb/hb_gate_seq_tb.sv
module hb_gate_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwm = 1'b0, sync = 1'b0, shdn_n = 1'b0, uvlo_ok = 1'b0;
  logic        hs_gate_high = 1'b0, ls_gate_high = 1'b0;
  logic [7:0]  dead_cycles = 8'd2;
  logic [11:0] timeout_cycles = 12'd20;
  logic        hs_en, ls_en, fault;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hb_gate_seq u_dut (
    .clk            (clk),
    .rst            (rst),
    .pwm            (pwm),
    .sync           (sync),
    .shdn_n         (shdn_n),
    .uvlo_ok        (uvlo_ok),
    .hs_gate_high   (hs_gate_high),
    .ls_gate_high   (ls_gate_high),
    .dead_cycles    (dead_cycles),
    .timeout_cycles (timeout_cycles),
    .hs_en          (hs_en),
    .ls_en          (ls_en),
    .fault          (fault)
  );

  // {shdn_n, uvlo_ok, sync, pwm, expected hs_en, expected ls_en}
  localparam logic [5:0] VEC [0:7] = '{
    6'b011100,  // shutdown overrides everything (R1)
    6'b110110,  // sync low, pwm high: high side (R2)
    6'b110000,  // sync low, pwm low: nothing (R2)
    6'b111001,  // sync high, pwm low: low side (R3)
    6'b111110,  // sync high, pwm high: high side (R3)
    6'b101100,  // supply invalid: nothing (R4)
    6'b111001,  // supply back, low side (R3)
    6'b011000   // shutdown again (R1)
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    check("R9", "hs_en in reset", hs_en, 1'b0);
    check("R9", "ls_en in reset", ls_en, 1'b0);
    check("R9", "fault in reset", fault, 1'b0);
    rst = 1'b0;
    step(1);
    check("R9", "hs_en after reset", hs_en, 1'b0);
    check("R9", "fault after reset", fault, 1'b0);

    // Table walk with both feedback flags low.
    for (int i = 0; i < 8; i++) begin
      {shdn_n, uvlo_ok, sync, pwm} = VEC[i][5:2];
      step(10);
      check("R1 R2 R3 R4 R5", $sformatf("vec %0d hs_en", i), hs_en, VEC[i][1]);
      check("R1 R2 R3 R4 R5", $sformatf("vec %0d ls_en", i), ls_en, VEC[i][0]);
      check("R5", $sformatf("vec %0d fault", i), fault, 1'b0);
    end

    // Latency and zero dead time, low side to high side.
    dead_cycles = 8'd0;
    shdn_n = 1'b1; uvlo_ok = 1'b1; sync = 1'b1; pwm = 1'b0;
    step(10);
    check("R3", "low side on", ls_en, 1'b1);
    pwm = 1'b1;
    step(2);
    check("R10", "ls_en held two edges", ls_en, 1'b1);
    step(1);
    check("R10", "ls_en off at third edge", ls_en, 1'b0);
    check("R6", "hs_en not yet on", hs_en, 1'b0);
    step(1);
    check("R7", "zero dead time hs_en on", hs_en, 1'b1);

    // Falling pwm with high-side gate still reported high.
    dead_cycles = 8'd2;
    hs_gate_high = 1'b1;
    pwm = 1'b0;
    step(10);
    check("R6", "ls_en held while hs gate high", ls_en, 1'b0);
    check("R6", "hs_en off after pwm fall", hs_en, 1'b0);
    check("R8", "no fault before limit", fault, 1'b0);
    hs_gate_high = 1'b0;
    step(2);
    check("R7", "ls_en off during dead time", ls_en, 1'b0);
    step(1);
    check("R7", "ls_en on after dead time", ls_en, 1'b1);

    // Rising pwm with low-side gate still reported high.
    ls_gate_high = 1'b1;
    pwm = 1'b1;
    step(10);
    check("R6", "hs_en held while ls gate high", hs_en, 1'b0);
    check("R6", "ls_en off after pwm rise", ls_en, 1'b0);
    ls_gate_high = 1'b0;
    step(3);
    check("R6", "hs_en on after ls gate low", hs_en, 1'b1);

    // Feedback timeout.
    hs_gate_high = 1'b1;
    pwm = 1'b0;
    step(23);
    check("R8", "fault not yet at limit", fault, 1'b0);
    step(1);
    check("R8", "fault at limit", fault, 1'b1);
    check("R8", "ls_en off in fault", ls_en, 1'b0);
    hs_gate_high = 1'b0;
    pwm = 1'b1;
    step(10);
    check("R8", "fault sticky", fault, 1'b1);
    check("R8", "hs_en off in fault", hs_en, 1'b0);
    rst = 1'b1;
    step(1);
    rst = 1'b0;
    step(1);
    check("R9", "fault cleared by reset", fault, 1'b0);
    check("R9", "hs_en off after reset", hs_en, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule